// File: doc/BRIEF.md
# Segment LCD Timing Controller

This block produces the drive timing for a multiplexed segment liquid-crystal panel with up to 8 common lines and 44 segment lines. It walks through the common lines in turn, one phase per line. The number of lines in use follows the duty setting. For every terminal it emits a 3-bit voltage-level code. An external analog stage turns each code into a real voltage. The codes depend on the bias setting, on which common line is active, on the pixel being lit, and on a frame polarity that flips every frame, so the panel sees no net DC.

Software loads pixel rows into a write buffer through a simple row-write port. The display reads from a separate display buffer. An update request copies the whole write buffer into the display buffer at the next frame boundary, so a half-written picture never appears. The pixels on segment 0 can blink, chosen per common line by a mask. During alternate blink periods they are forced off. One blink period is a programmable number of frames.

Top module: `segdrv_timing`

## Requirements
- R1: After reset, common 0 is active, the frame polarity is 0, both pixel buffers are clear, and the update pending and update done flags are 0.
- R2: Each common phase lasts phase_len+1 clocks. The active common steps 0,1,...,N-1 and then wraps, where N is 1, 2, 3, 4 or 8 for duty_sel 0, 1, 2, 3 and 4..7.
- R3: For bias_sel b the top level is T=b+1. At polarity 0 the active common drives T. An inactive common drives 1 (0 when b=0). A lit segment drives 0. An unlit segment drives T-1 (1 when b=0). Each terminal occupies bits [3k+2:3k] of its output bus.
- R4: The frame polarity toggles at every frame boundary. At polarity 1 every level L of a used terminal becomes T-L.
- R5: Commons with index N or above, and segments whose seg_en bit is 0, are held at level 0.
- R6: A row write (wr_en, wr_row, wr_data, where bit s is segment s) changes only the write buffer and has no effect on the outputs until a transfer.
- R7: upd_req sets the pending flag and clears the done flag. At the next frame boundary the write buffer is copied into the display buffer, pending clears and done sets. A request in the cycle of a boundary is served at that boundary.
- R8: A row write in the same cycle as a boundary transfer is not part of that transfer.
- R9: With P = max(blink_len,1), the blink phase starts at 0 and toggles after every P frames. While it is 1, the pixel at segment 0 of common c is shown off if blink_sel[c] is 1. No other pixel is affected.
- R10: frame_start is high for exactly the first clock of each frame after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_sel | input | 3 | Duty code: 0 static, 1 half, 2 third, 3 quarter, 4..7 eighth |
| bias_sel | input | 2 | Bias code: 0 static, 1 half, 2 third, 3 quarter |
| phase_len | input | CNT_W | Clocks per common phase minus one |
| seg_en | input | NSEG | Per-segment enable |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | clog2(NCOM) | Common row to write |
| wr_data | input | NSEG | Pixel bits for the row |
| upd_req | input | 1 | Request a buffer transfer at the next frame boundary |
| blink_sel | input | NCOM | Per-common blink mask for segment 0 |
| blink_len | input | BLK_W | Frames per blink period (0 acts as 1) |
| com_lvl | output | 3*NCOM | Level codes of the commons |
| seg_lvl | output | 3*NSEG | Level codes of the segments |
| frame_start | output | 1 | One-clock pulse at the start of a frame |
| frame_pol | output | 1 | Current frame polarity |
| upd_pend | output | 1 | Transfer requested and not yet done |
| upd_done | output | 1 | Transfer completed since the last request |

## Verification
Two functions can land on the same clock edge: the frame boundary that commits a transfer, and a software action, either a fresh update request or a row write. The bench provokes both on purpose. In every configuration it writes a changed row and asserts a request in the last clock of a frame. It then checks, cycle by cycle, that the request is served at that same boundary and that the row written in that clock stays hidden until a later request. Every duty and bias combination is swept, and each terminal's level is compared against values computed from the cycle count.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  // number of commons scanned for a duty code
  function automatic int unsigned com_count(logic [2:0] duty, int unsigned maxc);
    case (duty)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 4;
      default: return maxc;
    endcase
  endfunction

  function automatic lvl_t bias_top(logic [1:0] bias);
    return lvl_t'(bias) + lvl_t'(1);
  endfunction

  function automatic lvl_t flip_lvl(lvl_t l, lvl_t top, logic pol);
    return pol ? lvl_t'(top - l) : l;
  endfunction
endpackage

// File: rtl/lcdt_seq.sv
module lcdt_seq #(
  parameter int NCOM  = 8,
  parameter int CNT_W = 8,
  parameter int BLK_W = 8,
  localparam int COM_W = $clog2(NCOM),
  localparam int NC_W  = $clog2(NCOM + 1)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] phase_len_i,
  input  logic [NC_W-1:0]  ncom_i,
  input  logic [BLK_W-1:0] blink_len_i,
  output logic [COM_W-1:0] com_idx_o,
  output logic             pol_o,
  output logic             frame_wrap_o,
  output logic             frame_start_o,
  output logic             blink_off_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [COM_W-1:0] com_q, com_n;
  logic             pol_q, pol_n, fs_q, bph_q, bph_n;
  logic [BLK_W-1:0] bcnt_q, bcnt_n, blen_m1;
  logic             phase_end, at_last, wrap;

  assign phase_end = (cnt_q >= phase_len_i);
  assign at_last   = (NC_W'(com_q) + NC_W'(1)) >= ncom_i;
  assign wrap      = phase_end && at_last;
  assign blen_m1   = (blink_len_i == '0) ? '0 : blink_len_i - BLK_W'(1);

  always_comb begin
    cnt_n  = cnt_q + CNT_W'(1);
    com_n  = com_q;
    pol_n  = pol_q;
    bcnt_n = bcnt_q;
    bph_n  = bph_q;
    if (phase_end) begin
      cnt_n = '0;
      com_n = at_last ? '0 : com_q + COM_W'(1);
    end
    if (wrap) begin
      pol_n = ~pol_q;
      if (bcnt_q >= blen_m1) begin
        bcnt_n = '0;
        bph_n  = ~bph_q;
      end else begin
        bcnt_n = bcnt_q + BLK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      com_q  <= '0;
      pol_q  <= 1'b0;
      fs_q   <= 1'b0;
      bcnt_q <= '0;
      bph_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      com_q  <= com_n;
      pol_q  <= pol_n;
      fs_q   <= wrap;
      bcnt_q <= bcnt_n;
      bph_q  <= bph_n;
    end
  end

  assign com_idx_o     = com_q;
  assign pol_o         = pol_q;
  assign frame_wrap_o  = wrap;
  assign frame_start_o = fs_q;
  assign blink_off_o   = bph_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_end && !wrap) |=> (com_idx_o == $past(com_idx_o) + COM_W'(1)));
  p_pol_flip_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    frame_wrap_o |=> (pol_o != $past(pol_o)));
endmodule

// File: rtl/lcdt_pixbuf.sv
module lcdt_pixbuf #(
  parameter int NCOM = 8,
  parameter int NSEG = 44,
  localparam int COM_W = $clog2(NCOM)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [COM_W-1:0] wr_row_i,
  input  logic [NSEG-1:0]  wr_data_i,
  input  logic             upd_req_i,
  input  logic             frame_wrap_i,
  input  logic [COM_W-1:0] rd_row_i,
  output logic [NSEG-1:0]  rd_data_o,
  output logic             pend_o,
  output logic             done_o
);
  logic [NCOM-1:0][NSEG-1:0] wbuf_q, dbuf_q;
  logic pend_q, pend_n, done_q, done_n, xfer;

  assign xfer = frame_wrap_i && (pend_q || upd_req_i);

  always_comb begin
    pend_n = pend_q;
    done_n = done_q;
    if (xfer) begin
      pend_n = 1'b0;
      done_n = 1'b1;
    end else if (upd_req_i) begin
      pend_n = 1'b1;
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      done_q <= done_n;
    end
  end

  for (genvar r = 0; r < NCOM; r++) begin : g_row
    logic row_we;
    assign row_we = wr_en_i && (wr_row_i == COM_W'(r));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        wbuf_q[r] <= '0;
        dbuf_q[r] <= '0;
      end else begin
        if (row_we) wbuf_q[r] <= wr_data_i;
        if (xfer)   dbuf_q[r] <= wbuf_q[r];
      end
    end
  end

  assign rd_data_o = dbuf_q[rd_row_i];
  assign pend_o    = pend_q;
  assign done_o    = done_q;

  p_commit_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (frame_wrap_i && (pend_o || upd_req_i)) |=> (done_o && !pend_o));
  p_hidden_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !(frame_wrap_i && (pend_o || upd_req_i)) |=> $stable(dbuf_q));
endmodule

// File: rtl/lcdt_level.sv
module lcdt_level
  import lcdt_pkg::*;
#(
  parameter int NCOM = 8,
  parameter int NSEG = 44,
  localparam int COM_W = $clog2(NCOM),
  localparam int NC_W  = $clog2(NCOM + 1)
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic [NC_W-1:0]       ncom_i,
  input  logic [1:0]            bias_i,
  input  logic [COM_W-1:0]      com_idx_i,
  input  logic                  pol_i,
  input  logic [NSEG-1:0]       seg_en_i,
  input  logic [NSEG-1:0]       row_i,
  input  logic                  blank0_i,
  output logic [NCOM*LVL_W-1:0] com_lvl_o,
  output logic [NSEG*LVL_W-1:0] seg_lvl_o
);
  lvl_t top, com_idle, seg_off;

  assign top      = bias_top(bias_i);
  assign com_idle = (bias_i == 2'd0) ? lvl_t'(0) : lvl_t'(1);
  assign seg_off  = (bias_i == 2'd0) ? lvl_t'(1) : lvl_t'(top - lvl_t'(1));

  for (genvar i = 0; i < NCOM; i++) begin : g_com
    lvl_t base;
    logic used;
    assign used = (NC_W'(i) < ncom_i);
    assign base = (com_idx_i == COM_W'(i)) ? top : com_idle;
    assign com_lvl_o[i*LVL_W +: LVL_W] = used ? flip_lvl(base, top, pol_i) : '0;

    p_com_cap_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      com_lvl_o[i*LVL_W +: LVL_W] <= top);
    p_com_unused_r5: assert property (@(posedge clk) disable iff (!rst_ni)
      (ncom_i <= NC_W'(i)) |-> (com_lvl_o[i*LVL_W +: LVL_W] == '0));
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic lit;
    lvl_t base;
    if (s == 0) begin : g_blink
      assign lit = row_i[s] && !blank0_i;
    end else begin : g_plain
      assign lit = row_i[s];
    end
    assign base = lit ? lvl_t'(0) : seg_off;
    assign seg_lvl_o[s*LVL_W +: LVL_W] = seg_en_i[s] ? flip_lvl(base, top, pol_i) : '0;

    p_seg_cap_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      seg_lvl_o[s*LVL_W +: LVL_W] <= top);
  end
endmodule

// File: rtl/segdrv_timing.sv
module segdrv_timing #(
  parameter int NCOM  = 8,
  parameter int NSEG  = 44,
  parameter int CNT_W = 8,
  parameter int BLK_W = 8,
  localparam int COM_W = $clog2(NCOM),
  localparam int NC_W  = $clog2(NCOM + 1),
  localparam int LW    = lcdt_pkg::LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       duty_sel,
  input  logic [1:0]       bias_sel,
  input  logic [CNT_W-1:0] phase_len,
  input  logic [NSEG-1:0]  seg_en,
  input  logic             wr_en,
  input  logic [COM_W-1:0] wr_row,
  input  logic [NSEG-1:0]  wr_data,
  input  logic             upd_req,
  input  logic [NCOM-1:0]  blink_sel,
  input  logic [BLK_W-1:0] blink_len,
  output logic [NCOM*LW-1:0] com_lvl,
  output logic [NSEG*LW-1:0] seg_lvl,
  output logic             frame_start,
  output logic             frame_pol,
  output logic             upd_pend,
  output logic             upd_done
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [NC_W-1:0]  ncom;
  logic [COM_W-1:0] com_idx;
  logic             wrap, blink_off;
  logic [NSEG-1:0]  row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign ncom = NC_W'(lcdt_pkg::com_count(duty_sel, NCOM));

  lcdt_seq #(.NCOM(NCOM), .CNT_W(CNT_W), .BLK_W(BLK_W)) seq_i (
    .clk(clk), .rst_ni(rst_ni), .phase_len_i(phase_len), .ncom_i(ncom),
    .blink_len_i(blink_len), .com_idx_o(com_idx), .pol_o(frame_pol),
    .frame_wrap_o(wrap), .frame_start_o(frame_start), .blink_off_o(blink_off)
  );

  lcdt_pixbuf #(.NCOM(NCOM), .NSEG(NSEG)) buf_i (
    .clk(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_row_i(wr_row),
    .wr_data_i(wr_data), .upd_req_i(upd_req), .frame_wrap_i(wrap),
    .rd_row_i(com_idx), .rd_data_o(row), .pend_o(upd_pend), .done_o(upd_done)
  );

  lcdt_level #(.NCOM(NCOM), .NSEG(NSEG)) lvl_i (
    .clk(clk), .rst_ni(rst_ni), .ncom_i(ncom), .bias_i(bias_sel),
    .com_idx_i(com_idx), .pol_i(frame_pol), .seg_en_i(seg_en), .row_i(row),
    .blank0_i(blink_off && blink_sel[com_idx]),
    .com_lvl_o(com_lvl), .seg_lvl_o(seg_lvl)
  );

  p_fs_pol_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    frame_start |-> (frame_pol != $past(frame_pol)));
endmodule

// File: tb/segdrv_timing_tb_top.sv
module segdrv_timing_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCOM = 8;
  localparam int NSEG = 44;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] duty_sel;
  logic [1:0] bias_sel;
  logic [7:0] phase_len;
  logic [NSEG-1:0] seg_en;
  logic wr_en;
  logic [2:0] wr_row;
  logic [NSEG-1:0] wr_data;
  logic upd_req;
  logic [NCOM-1:0] blink_sel;
  logic [7:0] blink_len;
  logic [NCOM*3-1:0] com_lvl;
  logic [NSEG*3-1:0] seg_lvl;
  logic frame_start, frame_pol, upd_pend, upd_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segdrv_timing dut_i (
    .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .bias_sel(bias_sel),
    .phase_len(phase_len), .seg_en(seg_en), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .upd_req(upd_req), .blink_sel(blink_sel),
    .blink_len(blink_len), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .frame_start(frame_start), .frame_pol(frame_pol),
    .upd_pend(upd_pend), .upd_done(upd_done)
  );

  task automatic check(input bit ok, input string req, input logic [191:0] act,
                       input logic [191:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NSEG-1:0] pat(int r, int d, int b);
    logic [NSEG-1:0] v;
    for (int s = 0; s < NSEG; s++) v[s] = ((s*7 + r*3 + d + b) % 5) < 2;
    return v;
  endfunction

  function automatic int ncom_of(int d);
    return (d == 0) ? 1 : (d == 1) ? 2 : (d == 2) ? 3 : (d == 3) ? 4 : 8;
  endfunction

  function automatic int flp(int l, int top, int pol);
    return pol ? top - l : l;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NSEG-1:0] mw [NCOM];
    logic [NSEG-1:0] md [NCOM];
    logic [NCOM*3-1:0] ecom;
    logic [NSEG*3-1:0] eseg;
    bit mpend, mdone;
    wr_en = 0; upd_req = 0; wr_row = '0; wr_data = '0;
    for (int d = 0; d < 5; d++) begin
      for (int b = 0; b < 4; b++) begin
        int nc, lp, ff, top, cidle, soff, blen;
        nc = ncom_of(d); lp = (d + b) % 3; ff = (lp + 1) * nc;
        top = b + 1; cidle = (b == 0) ? 0 : 1; soff = (b == 0) ? 1 : b;
        blen = (b == 0) ? 1 : b;
        duty_sel = 3'(d); bias_sel = 2'(b); phase_len = 8'(lp);
        blink_sel = 8'hA5; blink_len = 8'(b);
        for (int s = 0; s < NSEG; s++) seg_en[s] = ((s + d) % 11) != 10;
        for (int r = 0; r < NCOM; r++) begin mw[r] = '0; md[r] = '0; end
        mpend = 0; mdone = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        for (int t = 0; t < 7 * ff; t++) begin
          int ct, fr, pol, bph;
          bit req, wr, wrap;
          int row;
          logic [NSEG-1:0] data;
          ct = (t / (lp + 1)) % nc; fr = t / ff; pol = fr % 2;
          bph = (fr / blen) % 2;
          for (int i = 0; i < NCOM; i++)
            ecom[i*3 +: 3] = (i >= nc) ? 3'd0 :
              3'(flp((i == ct) ? top : cidle, top, pol));
          for (int s = 0; s < NSEG; s++) begin
            bit lit;
            lit = md[ct][s] && !(s == 0 && bph == 1 && blink_sel[ct]);
            eseg[s*3 +: 3] = !seg_en[s] ? 3'd0 : 3'(flp(lit ? 0 : soff, top, pol));
          end
          if (t == 0)
            check(com_lvl[2:0] == 3'(top) && !frame_pol && !upd_pend && !upd_done &&
                  seg_lvl == eseg, "R1 reset state",
                  {com_lvl[2:0], frame_pol, upd_pend, upd_done},
                  {3'(top), 3'b000});
          // R2 R3 R4 R5 commons
          check(com_lvl == ecom, "R2 R3 R4 R5 common levels", 192'(com_lvl), 192'(ecom));
          // R3 R5 R6 R8 R9 segments
          check(seg_lvl == eseg, "R3 R5 R6 R8 R9 segment levels", 192'(seg_lvl), 192'(eseg));
          check(frame_pol == pol[0], "R4 polarity", 192'(frame_pol), 192'(pol));
          check(frame_start == (t > 0 && t % ff == 0), "R10 frame_start",
                192'(frame_start), 192'(t > 0 && t % ff == 0));
          check(upd_pend == mpend && upd_done == mdone, "R7 flags",
                {upd_pend, upd_done}, {mpend, mdone});
          req = 0; wr = 0; row = 0; data = '0;
          if (t < nc) begin wr = 1; row = t; data = pat(t, d, b); end
          if (t == nc) req = 1;
          if (t == 3 * ff - 1) begin
            // R8: row write and request in the clock of a boundary
            wr = 1; row = 0; data = ~pat(0, d, b); req = 1;
          end
          if (t == 4 * ff) req = 1;
          wr_en = wr; wr_row = 3'(row); wr_data = data; upd_req = req;
          wrap = ((t + 1) % ff) == 0;
          if (wrap && (mpend || req)) begin
            for (int r = 0; r < NCOM; r++) md[r] = mw[r];
            mpend = 0; mdone = 1;
          end else if (req) begin
            mpend = 1; mdone = 0;
          end
          if (wr) mw[row] = data;
          @(negedge clk);
        end
        wr_en = 0; upd_req = 0;
      end
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule